// File: doc/BRIEF.md
# Extended Data-Out Read Path Controller

This block owns the output side of a DRAM read path. It decides when each byte lane of the data bus is driven and what value that lane shows. Each lane keeps its value in a latch. The array supplies the read word, and the block loads that word into the latch of a lane when the lane's column strobe falls. All strobes are active low and sampled on the system clock. Both outputs are registered, so any sampled strobe pattern takes effect at the clock edge that samples it.

An input selects one of two output disciplines. In extended mode a lane keeps driving after its column strobe rises. It stops only when write enable falls, when the output-enable strobe rises, or when the row strobe and that lane's column strobe are both high. This lets a page-mode sequence overlap the data of one column with the addressing of the next. In conventional mode a lane drives only while its column strobe is low. Both modes fetch ahead: a flag marks the column address as valid, and while the row is open the block samples the array word under that flag. The latch then takes the sampled word at the next strobe fall, so the strobe does not have to fall before the read data is ready.

Top module: `edo_read_ctl`

## Requirements
- R1: While reset is asserted and after it is released with no strobe activity, every bit of `dq_en` and `dq_out` is 0.
- R2: In either mode, a sampled cycle with the row strobe low, the lane's column strobe low, the output-enable strobe low and write enable high sets every enable bit of that lane to 1 at that clock edge.
- R3: In extended mode, a lane that is driving stays driving after its column strobe goes high, as long as the row strobe and the output-enable strobe stay low and write enable stays high.
- R4: Write enable sampled low clears every bit of `dq_en` at that edge, in both modes. This covers a read-modify-write cycle.
- R5: The output-enable strobe sampled high clears every bit of `dq_en` at that edge, in both modes.
- R6: In extended mode, a lane is released when its column strobe and the row strobe are both sampled high. A high column strobe with the row strobe low does not release it.
- R7: In conventional mode, a lane is released at the first edge that samples its column strobe high.
- R8: A lane's latch loads only on a falling edge of its own column strobe that is sampled with the row strobe low and write enable high. Each new fall in a page-mode sequence replaces the held value. A fall sampled with write enable low leaves the latch unchanged. `dq_out` always shows the latch contents, whether or not the lane is enabled.
- R9: The value loaded is chosen by three rules. If the column-valid flag is high in the fall cycle, the value is the current array word. Otherwise, if the flag was high at some point since the row strobe last went low, the value is the array word sampled the last time the flag was high. Otherwise it is the current array word.
- R10: Lane 0 is bits 7:0 and follows `cas_n[0]`. Lane 1 is bits 15:8 and follows `cas_n[1]`. Enabling, releasing and loading of one lane never depend on the other lane's column strobe.
- R11: A released lane does not drive again until its column strobe is sampled low under the R2 conditions. The output-enable strobe returning low while the column strobe is high does not re-enable the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| edo_mode | input | 1 | 1 = extended hold, 0 = conventional page mode |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Column strobes, one per byte lane, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_valid | input | 1 | Column address valid flag |
| arr_data | input | 16 | Read word from the array |
| dq_en | output | 16 | Per-bit drive enable for the data bus |
| dq_out | output | 16 | Latched output data |

## Verification
The bench first targets the hold window after a column strobe rises, and then each of the three release events applied separately. A design that released on the column strobe would lose data in extended mode, and one that ignored write enable would fight the bus during read-modify-write. It also checks that the fetch-ahead register wins over a changed array word at the strobe fall. A design that latched the word at the fall instead would return the wrong column. Lane separation and write-cycle falls are checked through `dq_out`. A shared enable would drive the idle byte, and a design that loaded on write falls would corrupt the held value. Constrained random strobe traffic in both modes then mixes all of these with mode changes in the middle of a sequence.

// File: rtl/edo_rd_pkg.sv
// Package: shared widths and the per-lane output state encoding.
// Assumes byte-wide lanes; the lane count is set by the top.
package edo_rd_pkg;
    localparam int LANE_W_DEF = 8;
    localparam int LANES_DEF  = 2;

    typedef enum logic [1:0] {
        LN_OFF   = 2'd0,   // lane not driving
        LN_DRIVE = 2'd1,   // lane driving with its column strobe low
        LN_HOLD  = 2'd2    // lane driving past the column strobe rise
    } lane_state_t;
endpackage

// File: rtl/edo_rd_fetch.sv
// Module: fetch-ahead stage.
// While the row is open it keeps the array word sampled under the
// column-valid flag, and it picks the word that a strobe fall should load.
// Assumes the array word is stable whenever col_valid is high.
module edo_rd_fetch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          col_valid,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] load_word
);
    logic [DW-1:0] fetch_q;
    logic          fetch_vld;

    // Keep the most recent word seen under the valid flag for the open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q   <= '0;
            fetch_vld <= 1'b0;
        end else if (ras_n) begin
            fetch_vld <= 1'b0;
        end else if (col_valid) begin
            fetch_q   <= arr_data;
            fetch_vld <= 1'b1;
        end
    end

    // A live address takes the current word; otherwise the prefetched word if any.
    always_comb begin
        if (col_valid)      load_word = arr_data;
        else if (fetch_vld) load_word = fetch_q;
        else                load_word = arr_data;
    end
endmodule

// File: rtl/edo_rd_lane.sv
// Module: one byte lane of the output path.
// It holds the lane's data latch and decides when the lane drives.
// Assumes all strobes are already synchronous to clk.
module edo_rd_lane
    import edo_rd_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edo_mode,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [LANE_W-1:0] load_byte,
    output logic              lane_en,
    output logic [LANE_W-1:0] lane_data
);
    logic        cas_q;
    logic        cas_fall;
    logic        drive_ok;
    logic        release_ev;
    lane_state_t st_q, st_d;

    assign cas_fall   = cas_q & ~cas_n;
    assign drive_ok   = ~ras_n & ~cas_n & ~oe_n & we_n;
    assign release_ev = ~we_n | oe_n | (cas_n & ras_n);

    // Keep the previous column strobe sample for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cas_q <= 1'b1;
        else        cas_q <= cas_n;
    end

    // Load the latch on a read fall of this lane's column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                        lane_data <= '0;
        else if (cas_fall & ~ras_n & we_n) lane_data <= load_byte;
    end

    // Next drive state: start on a read strobe, then hold or release by mode.
    always_comb begin
        if (drive_ok)          st_d = LN_DRIVE;
        else if (!edo_mode)    st_d = LN_OFF;
        else if (st_q == LN_OFF) st_d = LN_OFF;
        else if (release_ev)   st_d = LN_OFF;
        else                   st_d = LN_HOLD;
    end

    // Register the drive state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LN_OFF;
        else        st_q <= st_d;
    end

    assign lane_en = (st_q != LN_OFF);
endmodule

// File: rtl/edo_read_ctl.sv
// Module: top of the read output path.
// It shares one fetch-ahead stage between the lanes, builds one lane
// controller per column strobe, and widens each lane enable to its bits.
// Assumes lane l occupies bits [l*LANE_W +: LANE_W].
module edo_read_ctl
    import edo_rd_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edo_mode,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             col_valid,
    input  logic [DW-1:0]    arr_data,
    output logic [DW-1:0]    dq_en,
    output logic [DW-1:0]    dq_out
);
    logic [DW-1:0]    load_word;
    logic [LANES-1:0] lane_en;

    edo_rd_fetch #(.DW(DW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .col_valid (col_valid),
        .arr_data  (arr_data),
        .load_word (load_word)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        edo_rd_lane #(.LANE_W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .edo_mode  (edo_mode),
            .ras_n     (ras_n),
            .cas_n     (cas_n[l]),
            .oe_n      (oe_n),
            .we_n      (we_n),
            .load_byte (load_word[l*LANE_W +: LANE_W]),
            .lane_en   (lane_en[l]),
            .lane_data (dq_out[l*LANE_W +: LANE_W])
        );
        assign dq_en[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
    end
endmodule

// File: rtl/edo_read_ctl_chk.sv
// Module: property checker for edo_read_ctl, attached by bind.
// Assumes the same lane layout as the top.
module edo_read_ctl_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edo_mode,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             oe_n,
    input logic             we_n,
    input logic [DW-1:0]    dq_en,
    input logic [DW-1:0]    dq_out
);
    // R4
    we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (dq_en == '0));

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_en == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_lchk
        // R2
        drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ras_n && !cas_n[l] && !oe_n && we_n) |=> dq_en[l*LANE_W]);

        // R3
        edo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edo_mode && !ras_n && !oe_n && we_n && dq_en[l*LANE_W])
                |=> dq_en[l*LANE_W]);

        // R6
        both_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ras_n && cas_n[l]) |=> !dq_en[l*LANE_W]);

        // R7
        conv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!edo_mode && cas_n[l]) |=> !dq_en[l*LANE_W]);

        // R8
        load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_out[l*LANE_W +: LANE_W] != $past(dq_out[l*LANE_W +: LANE_W]))
                |-> $past(!cas_n[l] && we_n));

        // R10
        lane_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_en[l*LANE_W +: LANE_W] == '0) || (dq_en[l*LANE_W +: LANE_W] == '1));
    end
endmodule

bind edo_read_ctl edo_read_ctl_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .edo_mode (edo_mode),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_en    (dq_en),
    .dq_out   (dq_out)
);

// File: tb/edo_read_ctl_tb.sv
// Bench for edo_read_ctl: directed corner cases followed by seeded random
// strobe traffic, each compared with a requirement-level model.
module edo_read_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        edo_mode;
    logic        ras_n;
    logic [1:0]  cas_n;
    logic        oe_n;
    logic        we_n;
    logic        col_valid;
    logic [15:0] arr_data;
    logic [15:0] dq_en;
    logic [15:0] dq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit        m_fv;
    bit [15:0] m_fq;
    bit [1:0]  m_cq;
    bit [1:0]  m_en;
    bit [15:0] m_d;

    always #10 clk = ~clk;

    edo_read_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode), .ras_n(ras_n),
        .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n), .col_valid(col_valid),
        .arr_data(arr_data), .dq_en(dq_en), .dq_out(dq_out)
    );

    function automatic bit [15:0] en_vec(bit [1:0] e);
        return {{8{e[1]}}, {8{e[0]}}};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance the model by one clock edge using the currently driven inputs.
    task automatic model_tick();
        bit [15:0] src;
        if (!rst_n) begin
            m_fv = 0; m_fq = '0; m_cq = 2'b11; m_en = 2'b00; m_d = '0;
            return;
        end
        src = col_valid ? arr_data : (m_fv ? m_fq : arr_data);
        for (int l = 0; l < 2; l++) begin
            bit drive, rel;
            if (m_cq[l] && !cas_n[l] && !ras_n && we_n)
                m_d[l*8 +: 8] = src[l*8 +: 8];
            drive = !ras_n && !cas_n[l] && !oe_n && we_n;
            rel   = !we_n || oe_n || (cas_n[l] && ras_n);
            if (drive)          m_en[l] = 1'b1;
            else if (!edo_mode) m_en[l] = 1'b0;
            else if (rel)       m_en[l] = 1'b0;
        end
        m_cq = cas_n;
        if (ras_n) m_fv = 0;
        else if (col_valid) begin m_fq = arr_data; m_fv = 1; end
    endtask

    // One clock: edge, then compare at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        model_tick();
        chk("R2 R3 R4 R5 R6 R7 R10 R11 enable", dq_en, en_vec(m_en));
        chk("R8 R9 R10 data", dq_out, m_d);
    endtask

    task automatic idle();
        ras_n = 1; cas_n = 2'b11; oe_n = 1; we_n = 1; col_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5151));
        rst_n = 0; edo_mode = 1; arr_data = '0; idle();
        @(negedge clk);
        step(); step();
        chk("R1 reset en", dq_en, 16'h0000);
        chk("R1 reset data", dq_out, 16'h0000);
        rst_n = 1;
        step();
        chk("R1 after release", dq_en | dq_out, 16'h0000);

        // R2 / R3 / R4: extended hold through a read-modify-write
        ras_n = 0; oe_n = 0; col_valid = 1; arr_data = 16'hA5C3; cas_n = 2'b00;
        step();
        chk("R2 drive", dq_en, 16'hFFFF);
        chk("R2 data", dq_out, 16'hA5C3);
        cas_n = 2'b11; col_valid = 0; arr_data = 16'h0000;
        step();
        chk("R3 hold after cas rise", dq_en, 16'hFFFF);
        chk("R3 data held", dq_out, 16'hA5C3);
        we_n = 0;
        step();
        chk("R4 we release", dq_en, 16'h0000);

        // R8: page-mode fall updates, write fall does not load
        we_n = 1; cas_n = 2'b00; col_valid = 1; arr_data = 16'h1234;
        step();
        cas_n = 2'b11; step();
        arr_data = 16'h5678; cas_n = 2'b00; step();
        chk("R8 page update", dq_out, 16'h5678);
        cas_n = 2'b11; step();
        we_n = 0; arr_data = 16'h7777; cas_n = 2'b00; step();
        chk("R8 write fall no load", dq_out, 16'h5678);
        we_n = 1; cas_n = 2'b11; step();

        // R5 / R11: oe release, no re-drive with cas high
        cas_n = 2'b00; step();
        cas_n = 2'b11; step();
        chk("R3 hold before oe", dq_en, 16'hFFFF);
        oe_n = 1; step();
        chk("R5 oe release", dq_en, 16'h0000);
        oe_n = 0; step();
        chk("R11 no re-drive", dq_en, 16'h0000);

        // R6: ras high with cas high releases
        cas_n = 2'b00; step();
        cas_n = 2'b11; ras_n = 1; step();
        chk("R6 both high release", dq_en, 16'h0000);

        // R9: prefetched word wins over a changed array word
        ras_n = 0; col_valid = 1; arr_data = 16'h1111; step();
        col_valid = 0; arr_data = 16'h2222; cas_n = 2'b00; step();
        chk("R9 prefetch", dq_out, 16'h1111);
        cas_n = 2'b11; ras_n = 1; step();

        // R7 / R10: conventional mode, lane 0 only
        edo_mode = 0; ras_n = 0; col_valid = 1; arr_data = 16'hBEEF; cas_n = 2'b10;
        step();
        chk("R10 lane0 only", dq_en, 16'h00FF);
        chk("R10 lane0 data", dq_out[7:0], 16'h00EF);
        cas_n = 2'b11; step();
        chk("R7 conv release", dq_en, 16'h0000);
        idle(); step();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) edo_mode = ~edo_mode;
            ras_n     = ($urandom_range(99) < 15);
            cas_n[0]  = $urandom_range(1);
            cas_n[1]  = $urandom_range(1);
            oe_n      = ($urandom_range(99) < 20);
            we_n      = ($urandom_range(99) >= 15);
            col_valid = ($urandom_range(99) < 40);
            arr_data  = 16'($urandom);
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule